// File: doc/BRIEF.md
# Bright Pixel Vector Frame Formatter

This block sits at the output end of a threshold-based image compressor. The compressor has ten parallel lanes. Each lane queues the bright pixels it finds as entries that hold brightness, a coarse column and a row. When an input frame ends, the per-lane counts for that frame are handed to this block with a start pulse. The formatter then builds a new camera-style frame. That frame carries one bright pixel vector per clock instead of raw pixels, so a standard frame grabber can capture it unchanged.

A lane buffer can already hold entries of the following input frame while the current frame drains. The block therefore pops exactly the latched count from each lane and leaves the rest in place. Lanes are served lowest index first. For every popped entry, the coarse column is turned into a full pixel column by multiplying it by the lane count and adding the lane index. Once the queued vectors are used up, the remaining slots of the frame are zero. The output frame has a fixed geometry: a set number of lines, each a set number of clocks long, with one blanking clock between lines.

Top module: `bpv_frame_formatter`

## Requirements
- R1: After synchronous reset, `fval_o`, `lval_o`, `data_o` and `rd_en_o` are all zero until a frame is started.
- R2: A start pulse that arrives while an output frame is in progress is ignored. The frame in progress keeps its counts and overflow flag, and no new frame follows from that pulse.
- R3: For each lane, exactly the latched count of entries is popped during a frame. Entries queued beyond that count are still at the head of the lane buffer after the frame.
- R4: Vectors are emitted lanes 0 through 9 in order, and in buffer order within a lane, one per active slot, starting at the first slot of the first line.
- R5: The head entry of a lane is 25 bits: bright in [7:0], coarse column in [14:8], row in [24:15]. The emitted column is 11 bits and equals coarse × 10 + lane, so coarse 127 on lane 9 gives 1279.
- R6: Each output word places brightness in bits 7:0, column in bits 18:8 and row in bits 28:19. Bits 30:29 are zero, and bytes 4 to 9 (bits 79:32) are always zero.
- R7: Bit 31 of the first slot of each frame carries the overflow flag latched with the start pulse. Bit 31 is zero in every other slot.
- R8: Every slot after the last vector of the frame, and every cycle in which `lval_o` is low, has all data bits zero, apart from the flag of R7.
- R9: `fval_o` stays high for LINES lines. `lval_o` is high for LINE_CLKS clocks per line, with exactly one clock of `lval_o` low between lines while `fval_o` stays high. Both fall together after the last line.
- R10: When a start pulse is sampled at a clock edge while the block is idle, the first output slot appears at the second edge after it.
- R11: At most one lane read enable is high in any cycle. A read enable is only asserted for a slot that is emitted with `lval_o` high at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: the counts of the input frame that just ended are valid |
| ovf_i | input | 1 | Overflow flag of that input frame, latched with start |
| lane_cnt_i | input | LANES*CNT_W | Per-lane entry counts; lane l at [l*CNT_W +: CNT_W] |
| lane_head_i | input | LANES*25 | Head entry of each lane buffer (show-ahead); lane l at [l*25 +: 25] |
| rd_en_o | output | LANES | Pop request per lane, one-hot or zero |
| fval_o | output | 1 | Output frame valid |
| lval_o | output | 1 | Output line valid |
| data_o | output | 80 | Ten-byte output word |

## Verification
The hardest case is a lane buffer that already holds entries belonging to the next frame while the current frame drains. The bench builds this directly. Before each start pulse it pushes extra entries behind the counted ones in its lane buffer models. It carries the leftover entries into the next frame's counts, then checks that exactly those extras remain at each head. A second hard case is a start pulse in the middle of a frame, which must be ignored. The bench injects one mid-line with different counts and an inverted overflow flag, then confirms that the frame contents and timing are unchanged.

// File: rtl/bpv_fmt_pkg.sv
package bpv_fmt_pkg;

    localparam int LANES     = 10;
    localparam int BRIGHT_W  = 8;
    localparam int COARSE_W  = 7;
    localparam int ROW_W     = 10;
    localparam int XFULL_W   = 11;
    localparam int BUS_BYTES = 10;
    localparam int BUS_W     = 8 * BUS_BYTES;
    localparam int IDX_W     = $clog2(LANES);

    typedef struct packed {
        logic [ROW_W-1:0]    row;
        logic [COARSE_W-1:0] coarse;
        logic [BRIGHT_W-1:0] bright;
    } lane_entry_t;

    localparam int ENTRY_W = $bits(lane_entry_t);

    typedef struct packed {
        logic                ovf;
        logic [1:0]          pad;
        logic [ROW_W-1:0]    row;
        logic [XFULL_W-1:0]  xcol;
        logic [BRIGHT_W-1:0] bright;
    } vec_word_t;

    localparam int WORD_W = $bits(vec_word_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LINE,
        ST_GAP
    } fmt_state_e;

    function automatic logic [XFULL_W-1:0] expand_x(
        input logic [COARSE_W-1:0] coarse,
        input logic [IDX_W-1:0]    lane
    );
        return XFULL_W'(coarse) * XFULL_W'(LANES) + XFULL_W'(lane);
    endfunction

endpackage

// File: rtl/bpv_lane_picker.sv
module bpv_lane_picker
    import bpv_fmt_pkg::*;
(
    input  logic [LANES-1:0] pending_i,
    output logic [LANES-1:0] grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // lowest-numbered lane with entries left wins
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pending_i[l]) begin
                grant_o    = '0;
                grant_o[l] = 1'b1;
                idx_o      = IDX_W'(l);
                any_o      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bpv_frame_timer.sv
module bpv_frame_timer
    import bpv_fmt_pkg::*;
#(
    parameter int LINE_CLKS = 128,
    parameter int LINES     = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    output fmt_state_e state_o,
    output logic       first_o
);
    localparam int COL_W = (LINE_CLKS > 1) ? $clog2(LINE_CLKS) : 1;
    localparam int LN_W  = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_CLKS - 1);
    localparam logic [LN_W-1:0]  LN_LAST  = LN_W'(LINES - 1);

    fmt_state_e       state_q;
    logic [COL_W-1:0] col_q;
    logic [LN_W-1:0]  ln_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            ln_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    col_q <= '0;
                    ln_q  <= '0;
                    if (start_i) state_q <= ST_LINE;
                end
                ST_LINE: begin
                    if (col_q == COL_LAST) begin
                        col_q <= '0;
                        if (ln_q == LN_LAST) begin
                            ln_q    <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            ln_q    <= ln_q + 1'b1;
                            state_q <= ST_GAP;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                ST_GAP:  state_q <= ST_LINE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign first_o = (state_q == ST_LINE) && (col_q == '0) && (ln_q == '0);
endmodule

// File: rtl/bpv_vector_pack.sv
module bpv_vector_pack
    import bpv_fmt_pkg::*;
(
    input  lane_entry_t      entry_i,
    input  logic [IDX_W-1:0] lane_i,
    input  logic             valid_i,
    input  logic             first_i,
    input  logic             ovf_i,
    output logic [BUS_W-1:0] bus_o
);
    vec_word_t word;

    always_comb begin
        word        = '0;
        word.ovf    = first_i & ovf_i;
        if (valid_i) begin
            word.bright = entry_i.bright;
            word.xcol   = expand_x(entry_i.coarse, lane_i);
            word.row    = entry_i.row;
        end
        bus_o = BUS_W'(word);
    end
endmodule

// File: rtl/bpv_frame_formatter.sv
module bpv_frame_formatter
    import bpv_fmt_pkg::*;
#(
    parameter int LINE_CLKS = 128,
    parameter int LINES     = 1024,
    parameter int CNT_W     = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     ovf_i,
    input  logic [LANES*CNT_W-1:0]   lane_cnt_i,
    input  logic [LANES*ENTRY_W-1:0] lane_head_i,
    output logic [LANES-1:0]         rd_en_o,
    output logic                     fval_o,
    output logic                     lval_o,
    output logic [BUS_W-1:0]         data_o
);
    fmt_state_e       state;
    logic             first_slot;
    logic             accept;
    logic             in_line;
    logic             ovf_q;
    logic [LANES-1:0] pending;
    logic [LANES-1:0] grant;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    lane_entry_t      heads [LANES];
    lane_entry_t      pick_entry;
    logic [BUS_W-1:0] slot_word;

    assign accept  = start_i && (state == ST_IDLE);
    assign in_line = (state == ST_LINE);

    bpv_frame_timer #(
        .LINE_CLKS (LINE_CLKS),
        .LINES     (LINES)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (accept),
        .state_o (state),
        .first_o (first_slot)
    );

    // per-lane remaining-entry counters
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CNT_W-1:0] remain_q;

        always_ff @(posedge clk) begin
            if (rst)             remain_q <= '0;
            else if (accept)     remain_q <= lane_cnt_i[l*CNT_W +: CNT_W];
            else if (rd_en_o[l]) remain_q <= remain_q - 1'b1;
        end

        assign pending[l] = (remain_q != '0);
        assign heads[l]   = lane_entry_t'(lane_head_i[l*ENTRY_W +: ENTRY_W]);
    end

    bpv_lane_picker picker_i (
        .pending_i (pending),
        .grant_o   (grant),
        .idx_o     (pick_idx),
        .any_o     (pick_any)
    );

    assign rd_en_o = in_line ? grant : '0;

    always_comb begin
        pick_entry = '0;
        for (int l = 0; l < LANES; l++) begin
            if (grant[l]) pick_entry = heads[l];
        end
    end

    bpv_vector_pack pack_i (
        .entry_i (pick_entry),
        .lane_i  (pick_idx),
        .valid_i (pick_any),
        .first_i (first_slot),
        .ovf_i   (ovf_q),
        .bus_o   (slot_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q  <= 1'b0;
            fval_o <= 1'b0;
            lval_o <= 1'b0;
            data_o <= '0;
        end else begin
            if (accept) ovf_q <= ovf_i;
            fval_o <= (state != ST_IDLE);
            lval_o <= in_line;
            data_o <= in_line ? slot_word : '0;
        end
    end
endmodule

// File: rtl/bpv_frame_formatter_chk.sv
module bpv_frame_formatter_chk
    import bpv_fmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] rd_en_o,
    input logic             fval_o,
    input logic             lval_o,
    input logic [BUS_W-1:0] data_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!fval_o && !lval_o && data_o == '0));

    assert_one_lane_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_en_o));

    assert_read_in_line_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o != '0) |=> lval_o);

    assert_upper_bytes_zero_R6: assert property (@(posedge clk) disable iff (rst)
        data_o[BUS_W-1:WORD_W] == '0 && data_o[30:29] == 2'b00);

    assert_lval_in_fval_R9: assert property (@(posedge clk) disable iff (rst)
        lval_o |-> fval_o);

    assert_single_gap_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(lval_o) && fval_o) |=> lval_o);

    assert_frame_opens_line_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fval_o) |-> lval_o);

    assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !lval_o |-> (data_o == '0));
endmodule

bind bpv_frame_formatter bpv_frame_formatter_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en_o (rd_en_o),
    .fval_o  (fval_o),
    .lval_o  (lval_o),
    .data_o  (data_o)
);

// File: tb/bpv_frame_formatter_tb.sv
module bpv_frame_formatter_tb_top;
    import bpv_fmt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_CLKS  = 16;
    localparam int LINES      = 4;
    localparam int CNT_W      = 10;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     start_i = 1'b0;
    logic                     ovf_i = 1'b0;
    logic [LANES*CNT_W-1:0]   lane_cnt_i = '0;
    logic [LANES*ENTRY_W-1:0] lane_head_i = '0;
    logic [LANES-1:0]         rd_en_o;
    logic                     fval_o;
    logic                     lval_o;
    logic [BUS_W-1:0]         data_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [ENTRY_W-1:0] fifo_q [LANES][$];
    logic [LANES-1:0]   pend = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bpv_frame_formatter #(
        .LINE_CLKS (LINE_CLKS),
        .LINES     (LINES),
        .CNT_W     (CNT_W)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .ovf_i       (ovf_i),
        .lane_cnt_i  (lane_cnt_i),
        .lane_head_i (lane_head_i),
        .rd_en_o     (rd_en_o),
        .fval_o      (fval_o),
        .lval_o      (lval_o),
        .data_o      (data_o)
    );

    task automatic chk(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // capture pop requests mid-cycle; R11 one-hot read check
    always @(negedge clk) begin
        pend = rd_en_o;
        if (!rst && !done) chk("R11", BUS_W'($countones(rd_en_o) <= 1), BUS_W'(1));
    end

    // lane buffer models: pop after the edge the design used the head
    always @(posedge clk) begin
        #1;
        for (int l = 0; l < LANES; l++) begin
            if (pend[l]) begin
                if (fifo_q[l].size() == 0) chk("R3", BUS_W'(1), BUS_W'(0));
                else void'(fifo_q[l].pop_front());
            end
            lane_head_i[l*ENTRY_W +: ENTRY_W] = (fifo_q[l].size() != 0) ? fifo_q[l][0] : '0;
        end
    end

    function automatic logic [ENTRY_W-1:0] make_entry(input bit max_col);
        logic [ROW_W-1:0]    r;
        logic [COARSE_W-1:0] c;
        logic [BRIGHT_W-1:0] b;
        r = ROW_W'($urandom);
        c = max_col ? '1 : COARSE_W'($urandom);
        b = BRIGHT_W'($urandom);
        return {r, c, b};
    endfunction

    function automatic logic [WORD_W-1:0] expect_word(input logic [ENTRY_W-1:0] e, input int lane);
        logic [XFULL_W-1:0] xc;
        xc = XFULL_W'(e[14:8]) * XFULL_W'(10) + XFULL_W'(lane);
        return {1'b0, 2'b00, e[24:15], xc, e[7:0]};
    endfunction

    task automatic run_frame(input int add [LANES], input int extra [LANES],
                             input bit ovf, input bit max_col, input bit mid_start);
        logic [WORD_W-1:0]  exp_w [$];
        logic [ENTRY_W-1:0] extra_head [LANES];
        int                 cnt [LANES];
        logic [WORD_W-1:0]  w;
        int                 k;
        string              tag;
        for (int l = 0; l < LANES; l++) begin
            for (int i = 0; i < add[l]; i++) fifo_q[l].push_back(make_entry(max_col));
            cnt[l] = fifo_q[l].size();
            for (int i = 0; i < cnt[l]; i++) exp_w.push_back(expect_word(fifo_q[l][i], l));
            for (int i = 0; i < extra[l]; i++) fifo_q[l].push_back(make_entry(1'b0));
            extra_head[l] = (extra[l] != 0) ? fifo_q[l][cnt[l]] : '0;
        end
        @(negedge clk);
        start_i = 1'b1;
        ovf_i   = ovf;
        for (int l = 0; l < LANES; l++) lane_cnt_i[l*CNT_W +: CNT_W] = CNT_W'(cnt[l]);
        @(negedge clk);
        start_i = 1'b0;
        chk("R10", {fval_o, lval_o, data_o}, '0);
        k = 0;
        for (int ln = 0; ln < LINES; ln++) begin
            for (int c = 0; c < LINE_CLKS; c++) begin
                @(negedge clk);
                if (mid_start && k == 3) begin
                    start_i = 1'b1;
                    ovf_i   = ~ovf;
                    lane_cnt_i = '1;
                end
                if (mid_start && k == 4) start_i = 1'b0;
                w = (k < exp_w.size()) ? exp_w[k] : '0;
                if (k == 0) w[31] = ovf;
                if (k == 0)                tag = "R7";
                else if (mid_start)        tag = "R2";
                else if (k < exp_w.size()) tag = max_col ? "R5" : "R4";
                else                       tag = "R8";
                chk("R9", BUS_W'({fval_o, lval_o}), BUS_W'(2'b11));
                chk(tag, data_o, BUS_W'(w));
                chk("R6", BUS_W'(data_o[BUS_W-1:WORD_W]), '0);
                k++;
            end
            @(negedge clk);
            if (ln == LINES - 1) chk("R9", BUS_W'({fval_o, lval_o}), BUS_W'(2'b00));
            else                 chk("R9", {fval_o, lval_o, data_o}, {2'b10, {BUS_W{1'b0}}});
        end
        repeat (3) @(negedge clk);
        chk(mid_start ? "R2" : "R9", BUS_W'(fval_o), '0);
        for (int l = 0; l < LANES; l++) begin
            chk("R3", BUS_W'(fifo_q[l].size()), BUS_W'(extra[l]));
            if (extra[l] != 0) chk("R3", BUS_W'(lane_head_i[l*ENTRY_W +: ENTRY_W]), BUS_W'(extra_head[l]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int add [LANES];
        int extra [LANES];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", {fval_o, lval_o, data_o}, '0);
        chk("R1", BUS_W'(rd_en_o), '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", {fval_o, lval_o, data_o, BUS_W'(rd_en_o)}, '0);

        // empty frame with overflow flag set
        for (int l = 0; l < LANES; l++) begin add[l] = 0; extra[l] = 0; end
        run_frame(add, extra, 1'b1, 1'b0, 1'b0);

        // random frames with next-frame entries queued behind
        for (int f = 0; f < 4; f++) begin
            for (int l = 0; l < LANES; l++) begin
                add[l]   = int'($urandom % 4);
                extra[l] = int'($urandom % 3);
            end
            run_frame(add, extra, 1'($urandom), 1'b0, 1'b0);
        end

        // widest column values
        for (int l = 0; l < LANES; l++) begin add[l] = 2; extra[l] = 1; end
        run_frame(add, extra, 1'b0, 1'b1, 1'b0);

        // start pulse injected mid-frame
        for (int l = 0; l < LANES; l++) begin add[l] = int'($urandom % 3); extra[l] = 0; end
        run_frame(add, extra, 1'b1, 1'b0, 1'b1);

        // only the last lane holds entries
        for (int l = 0; l < LANES; l++) begin add[l] = (l == LANES - 1) ? 5 : 0; extra[l] = 0; end
        run_frame(add, extra, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule